// File: doc/BRIEF.md
# Auto-Program Non-Volatile Word Store Controller

This block sits between a simple single-cycle memory-mapped bus and a small on-chip array of 32-bit non-volatile words. The bus reaches it through two windows, selected by `busWindow`. The control window (`busWindow` = 0) holds five locations: a program-mode selector, a clock divider, a power-down switch, an end-of-program status word, and a write-one-to-clear location for that status. The data window (`busWindow` = 1) maps the array on a 4-byte stride.

Software first wakes the array and waits out the wake-up interval. It then selects single-word mode and writes a word into the data window. That one write latches the data and the target index. It also starts a timed erase/program cycle, which is paced by a tick taken from the bus clock through the divider. When the cycle ends, the word lands in the array and a sticky end-of-program flag is raised. Software polls the flag and clears it. The last page of the array holds initialisation data and refuses writes.

The array is a plain register array. The programming time is a tick count set by a parameter, so a test can shorten it.

Top module: `nvm_autoprog_ctrl`

## Requirements
- R1: After reset the array is powered down, the divider is 0, the mode selector is 0, the status word is 0 and `busy` is low. Control-window reads return these values: 0x018 reads 1, and 0x014, 0x00C and 0xFE0 read 0.
- R2: Control-window locations read back as follows. Offset 0x00C returns 1 in bit 0 when the last value written was exactly 1, and 0 otherwise. Offset 0x014 returns the divider in its low DIV_W bits. Offset 0x018 returns the power-down state in bit 0. Offset 0xFE0 returns the end-of-program flag in bit 2.
- R3: Writing bit 0 = 1 to offset 0x018 powers the array down. Writing bit 0 = 0 while it is powered down wakes it, and it then stays inaccessible for WAKE_CYCLES clock cycles. While the array is powered down or inaccessible, data-window reads return 0 and data-window writes change nothing and start no cycle.
- R4: A data-window write starts a program cycle only when offset 0x00C holds 1. With any other mode value the write changes nothing and leaves `busy` low.
- R5: An accepted write raises `busy` from the next cycle. `busy` stays high for exactly PROG_TICKS × (divider + 1) clock cycles.
- R6: When the cycle ends, the latched word is readable at its index. Bit 2 of offset 0xFE0 is set at the same time and stays set until it is cleared.
- R7: A write to offset 0xFE8 with bit 2 = 1 clears the flag. The same write with bit 2 = 0 leaves the flag set.
- R8: While `busy` is high, further data-window writes are ignored. A read of the word being programmed returns its old value until the cycle ends.
- R9: A data-window write to word index WORDS − PAGE_BYTES/4 or above is rejected and starts no cycle. A write to the index just below that boundary is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWindow | input | 1 | 0 = control window, 1 = data window |
| busAddr | input | ADDR_W | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| busy | output | 1 | Program cycle in progress |

## Verification
The hardest situation to reach from the ports is a program cycle that is still running when the bus sends another write and a read of the word being programmed. The old contents must show, and the second write must leave no trace. The bench reaches this state by using a divider above zero, so the cycle lasts long enough. It issues the competing accesses right after the starting write and inspects both words once `busy` drops. The power-down path is reached by programming a word, sleeping, and then reading the same word back through the wake-up interval.

// File: rtl/nvm_autoprog_pkg.sv
package nvm_autoprog_pkg;
  localparam logic [11:0] OFS_MODE   = 12'h00C;
  localparam logic [11:0] OFS_DIV    = 12'h014;
  localparam logic [11:0] OFS_SLEEP  = 12'h018;
  localparam logic [11:0] OFS_STAT   = 12'hFE0;
  localparam logic [11:0] OFS_CLR    = 12'hFE8;
  localparam int          DONE_BIT   = 2;

  typedef struct packed {
    logic latchEn;   // capture index and data of an accepted write
    logic commitEn;  // last tick: move latched word into the array
    logic readEn;    // array awake and accessible
  } nvmStrobe_t;
endpackage

// File: rtl/nvm_autoprog_ctl.sv
module nvm_autoprog_ctl
  import nvm_autoprog_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORDS       = 64,
  parameter int PAGE_BYTES  = 128,
  parameter int DIV_W       = 8,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busWindow,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       regRdata,
  output logic              busy,
  output logic              pwrDown,
  output logic              eopFlag,
  output nvmStrobe_t        strobe
);
  localparam int IDX_W      = $clog2(WORDS);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int WRITABLE   = WORDS - PAGE_WORDS;
  localparam int TICK_W     = $clog2(PROG_TICKS + 1);
  localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1);

  logic              modeSingle;
  logic [DIV_W-1:0]  divReg;
  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [WAKE_W-1:0] wakeCnt;
  logic              regWr;
  logic              dataWr;
  logic              accessible;
  logic              writable;
  logic              startProg;
  logic              tickHit;
  logic              lastTick;
  logic              clrHit;
  logic [IDX_W-1:0]  wordIdx;

  assign regWr      = busValid && busWrite && !busWindow;
  assign dataWr     = busValid && busWrite && busWindow;
  assign accessible = !pwrDown && (wakeCnt == '0);
  assign wordIdx    = busAddr[2 +: IDX_W];
  assign writable   = ({1'b0, wordIdx} < (IDX_W + 1)'(WRITABLE));
  assign startProg  = dataWr && accessible && modeSingle && !busy && writable;
  assign tickHit    = busy && (divCnt == divReg);
  assign lastTick   = tickHit && (tickCnt == TICK_W'(PROG_TICKS - 1));
  assign clrHit     = regWr && (busAddr[11:0] == OFS_CLR) && busWdata[DONE_BIT];

  assign strobe.latchEn  = startProg;
  assign strobe.commitEn = lastTick;
  assign strobe.readEn   = accessible;

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSingle <= 1'b0;
      divReg     <= '0;
      pwrDown    <= 1'b1;
      wakeCnt    <= '0;
    end else begin
      if (regWr && busAddr[11:0] == OFS_MODE) modeSingle <= (busWdata == 32'd1);
      if (regWr && busAddr[11:0] == OFS_DIV)  divReg     <= busWdata[DIV_W-1:0];
      if (regWr && busAddr[11:0] == OFS_SLEEP) begin
        if (busWdata[0]) begin
          pwrDown <= 1'b1;
          wakeCnt <= '0;
        end else if (pwrDown) begin
          pwrDown <= 1'b0;
          wakeCnt <= WAKE_W'(WAKE_CYCLES);
        end
      end else if (!pwrDown && wakeCnt != '0) begin
        wakeCnt <= wakeCnt - 1'b1;
      end
    end
  end

  // program sequencer paced by divided tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (startProg) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (busy) begin
      if (tickHit) begin
        divCnt <= '0;
        if (lastTick) busy <= 1'b0;
        else          tickCnt <= tickCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // sticky completion flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)         eopFlag <= 1'b0;
    else if (lastTick) eopFlag <= 1'b1;
    else if (clrHit)   eopFlag <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (busAddr[11:0])
      OFS_MODE:  regRdata[0]          = modeSingle;
      OFS_DIV:   regRdata[DIV_W-1:0]  = divReg;
      OFS_SLEEP: regRdata[0]          = pwrDown;
      OFS_STAT:  regRdata[DONE_BIT]   = eopFlag;
      default:   regRdata             = '0;
    endcase
  end
endmodule

// File: rtl/nvm_autoprog_dp.sv
module nvm_autoprog_dp
  import nvm_autoprog_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nvmStrobe_t       strobe,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [31:0]      busWdata,
  output logic [31:0]      dataRdata
);
  logic [31:0]      cells [WORDS];
  logic [IDX_W-1:0] pendIdx;
  logic [31:0]      pendData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendIdx  <= '0;
      pendData <= '0;
    end else if (strobe.latchEn) begin
      pendIdx  <= wordIdx;
      pendData <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= '0;
    end else if (strobe.commitEn) begin
      cells[pendIdx] <= pendData;
    end
  end

  assign dataRdata = strobe.readEn ? cells[wordIdx] : 32'd0;
endmodule

// File: rtl/nvm_autoprog_ctrl.sv
module nvm_autoprog_ctrl
  import nvm_autoprog_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORDS       = 64,
  parameter int PAGE_BYTES  = 128,
  parameter int DIV_W       = 8,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busWindow,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busy
);
  localparam int IDX_W = $clog2(WORDS);

  nvmStrobe_t  strobe;
  logic [31:0] regRdata;
  logic [31:0] dataRdata;
  logic        pwrDown;
  logic        eopFlag;
  logic        commitEn;

  assign commitEn = strobe.commitEn;

  nvm_autoprog_ctl #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .PAGE_BYTES(PAGE_BYTES), .DIV_W(DIV_W),
    .PROG_TICKS(PROG_TICKS), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWindow(busWindow), .busAddr(busAddr), .busWdata(busWdata),
    .regRdata(regRdata), .busy(busy), .pwrDown(pwrDown), .eopFlag(eopFlag),
    .strobe(strobe)
  );

  nvm_autoprog_dp #(.WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(busAddr[2 +: IDX_W]),
    .busWdata(busWdata), .dataRdata(dataRdata)
  );

  assign busRdata = busWindow ? dataRdata : regRdata;
endmodule

// File: rtl/nvm_autoprog_checker.sv
module nvm_autoprog_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic              busWindow,
  input logic [ADDR_W-1:0] busAddr,
  input logic              clrBit,
  input logic [31:0]       busRdata,
  input logic              busy,
  input logic              pwrDown,
  input logic              eopFlag,
  input logic              commitEn
);
  logic clrHit;
  assign clrHit = busValid && busWrite && !busWindow && (busAddr[11:0] == 12'hFE8) && clrBit;

  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busValid && busWrite && busWindow && !pwrDown)); // R4
  AST_SLEEP_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busWindow && pwrDown) |-> (busRdata == 32'd0)); // R3
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> eopFlag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (eopFlag && !clrHit) |=> eopFlag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && !commitEn) |=> !eopFlag); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commitEn) |=> busy); // R8
endmodule

bind nvm_autoprog_ctrl nvm_autoprog_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busWindow(busWindow), .busAddr(busAddr), .clrBit(busWdata[2]),
  .busRdata(busRdata), .busy(busy), .pwrDown(pwrDown), .eopFlag(eopFlag),
  .commitEn(commitEn)
);

// File: tb/tb_nvm_autoprog_ctrl.sv
module tb_nvm_autoprog_ctrl;
  localparam int ADDR_W = 12, WORDS = 64, PAGE_BYTES = 128, DIV_W = 8;
  localparam int PROG_TICKS = 5, WAKE_CYCLES = 8;
  localparam int LAST_OK = WORDS - PAGE_BYTES / 4 - 1;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0, busWindow = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busy;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  nvm_autoprog_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .PAGE_BYTES(PAGE_BYTES),
    .DIV_W(DIV_W), .PROG_TICKS(PROG_TICKS), .WAKE_CYCLES(WAKE_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWindow(busWindow), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busy(busy));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic win, logic [11:0] addr, logic [31:0] d);
    busValid = 1; busWrite = 1; busWindow = win; busAddr = addr; busWdata = d;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic win, logic [11:0] addr, output logic [31:0] d);
    busValid = 1; busWrite = 0; busWindow = win; busAddr = addr;
    #1 d = busRdata;
    busValid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 10000) begin n++; @(posedge clk); #1; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 12'h018, v); check("R1 sleep", v, 1);
    rd(0, 12'h014, v); check("R1 div", v, 0);
    rd(0, 12'h00C, v); check("R1 mode", v, 0);
    rd(0, 12'hFE0, v); check("R1 stat", v, 0);
    check("R1 busy", {31'b0, busy}, 0);
  endtask

  task automatic t_wake();
    logic [31:0] v;
    wr(0, 12'h018, 0);
    rd(0, 12'h018, v); check("R2 sleep rb", v, 0);
    idle(WAKE_CYCLES);
  endtask

  task automatic t_mode_off();
    logic [31:0] v;
    wr(0, 12'h00C, 32'h3);
    rd(0, 12'h00C, v); check("R2 mode rb", v, 0);
    wr(1, 12'h00C, 32'h1234);
    check("R4 no start", {31'b0, busy}, 0);
    idle(PROG_TICKS + 2);
    rd(1, 12'h00C, v); check("R4 unchanged", v, 0);
  endtask

  task automatic t_program();
    logic [31:0] v; int n;
    wr(0, 12'h00C, 1);
    rd(0, 12'h00C, v); check("R2 mode rb1", v, 1);
    wr(1, 12'h00C, 32'hA5A5_0003);
    busyLen(n); check("R5 len div0", n, PROG_TICKS);
    rd(1, 12'h00C, v); check("R6 stored", v, 32'hA5A5_0003);
    rd(0, 12'hFE0, v); check("R6 flag", v, 4);
    idle(20);
    rd(0, 12'hFE0, v); check("R6 sticky", v, 4);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(0, 12'hFE8, 32'hFFFF_FFFB);
    rd(0, 12'hFE0, v); check("R7 bit2 zero", v, 4);
    wr(0, 12'hFE8, 4);
    rd(0, 12'hFE0, v); check("R7 cleared", v, 0);
  endtask

  task automatic t_div();
    logic [31:0] v; int n;
    wr(0, 12'h014, 2);
    rd(0, 12'h014, v); check("R2 div rb", v, 2);
    wr(1, 12'h014, 32'h0000_5555);
    busyLen(n); check("R5 len div2", n, PROG_TICKS * 3);
    rd(1, 12'h014, v); check("R6 stored div2", v, 32'h5555);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(1, 12'h00C, 32'hC0DE_0003);
    check("R8 busy up", {31'b0, busy}, 1);
    wr(1, 12'h01C, 32'hDEAD_0007);
    rd(1, 12'h00C, v); check("R8 old value", v, 32'hA5A5_0003);
    idle(PROG_TICKS * 3 + 2);
    check("R8 busy down", {31'b0, busy}, 0);
    rd(1, 12'h00C, v); check("R8 new value", v, 32'hC0DE_0003);
    rd(1, 12'h01C, v); check("R8 ignored", v, 0);
    wr(0, 12'h014, 0);
  endtask

  task automatic t_lastpage();
    logic [31:0] v;
    wr(1, 12'((LAST_OK + 1) * 4), 32'h1111_2222);
    check("R9 reject", {31'b0, busy}, 0);
    idle(PROG_TICKS + 2);
    rd(1, 12'((LAST_OK + 1) * 4), v); check("R9 untouched", v, 0);
    wr(1, 12'(LAST_OK * 4), 32'h3333_4444);
    check("R9 boundary accepted", {31'b0, busy}, 1);
    idle(PROG_TICKS + 2);
    rd(1, 12'(LAST_OK * 4), v); check("R9 boundary stored", v, 32'h3333_4444);
  endtask

  task automatic t_sleep();
    logic [31:0] v;
    wr(0, 12'h018, 1);
    rd(1, 12'h00C, v); check("R3 asleep read", v, 0);
    wr(1, 12'h010, 32'h7777_0004);
    check("R3 asleep write", {31'b0, busy}, 0);
    wr(0, 12'h018, 0);
    idle(WAKE_CYCLES - 2);
    rd(1, 12'h00C, v); check("R3 waking read", v, 0);
    idle(2);
    rd(1, 12'h00C, v); check("R3 awake read", v, 32'hC0DE_0003);
    rd(1, 12'h010, v); check("R3 dropped write", v, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    t_reset();
    t_wake();
    t_mode_off();
    t_program();
    t_clear();
    t_div();
    t_busy();
    t_lastpage();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule